// File: doc/BRIEF.md
# Edge-Triggered Timestamp Capture Unit

This block timestamps events on three input pins against a free-running 16-bit counter that is supplied from outside. Each pin goes through its own two-flop synchronizer. An edge detector then compares the synchronized level with its value one cycle earlier. Each channel watches for the transition chosen for it. When that transition arrives, the channel copies the counter into its capture register and sets its flag.

A host uses a small register port to set up and read the block:
- a 2-bit edge-selection field for each channel;
- an interrupt-enable mask;
- a flag register, where writing 1 to a bit clears that flag;
- one read-only capture register per channel.

The host gets an interval by subtracting two successive captures. Capturing on a rising edge and then on a falling edge gives a pulse width. A level interrupt output is high while any flag is set whose enable bit is also set.

Top module: `ts_capture_unit`

## Requirements
- R1: After reset, every register reads zero and irq_o is low. The registers are edge selection (address 0), interrupt enable (address 1), flags (address 2) and captures (addresses 3, 4, 5 for channels 0, 1, 2).
- R2: With edge code 01 (rising), a 0-to-1 change on a channel's pin is captured. The capture register takes the count_i value sampled at the third rising clock edge after the pin changes, and the channel's flag (bit c of address 2) sets at that same edge.
- R3: With edge code 10 (falling), only a 1-to-0 change on the pin captures and sets the flag. A 0-to-1 change does neither.
- R4: With edge code 11 (either), both directions of change capture and set the flag.
- R5: With edge code 00 (disabled), pin changes leave the capture register and the flag unchanged.
- R6: Writing 1 to a flag bit at address 2 clears that flag. Writing 0 leaves it as it is.
- R7: irq_o is high exactly when some channel has both its flag set and its enable bit set (bit c of address 1).
- R8: A new qualifying edge overwrites the capture register even while the flag is still set.
- R9: If a capture and a host clear of the same flag fall in the same cycle, the flag ends up set.
- R10: Channel c's edge field sits at bits [2c+1:2c] of address 0. A capture on one channel changes no other channel's capture register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 16 | Free-running timebase to timestamp |
| pin_i | input | 3 | Asynchronous capture inputs, one per channel |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 4 | Host register address |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data for host_addr_i, combinational |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The bench builds the block with its defaults: three channels, a 16-bit counter and a two-stage synchronizer. At this size it can sweep every channel through all four edge codes and both pin directions. That is 24 cases, each checking the captured count, the whole flag vector and the capture registers of the other channels. The counter advances once per cycle, so every timestamp is a distinct value the bench computes arithmetically. This exposes a latency that is off by one cycle. Targeted sequences place a host clear in the exact capture cycle, and apply a second edge while the flag is still set.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  localparam int unsigned REG_EDGE = 0;
  localparam int unsigned REG_IEN  = 1;
  localparam int unsigned REG_FLAG = 2;
  localparam int unsigned REG_CAP0 = 3;
endpackage

// File: rtl/ts_sync.sv
module ts_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ts_edge_det.sv
module ts_edge_det
  import ts_cap_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  edge_sel_e sel_i,
  output logic      hit_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_ANY:  hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ts_cap_channel.sv
module ts_cap_channel
  import ts_cap_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  edge_sel_e        sel_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             clr_i,
  output logic             hit_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] cap_o
);
  logic lvl;

  ts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  ts_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .sel_i (sel_i),
    .hit_o (hit_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_o <= '0;
    else if (hit_o) cap_o <= count_i;
  end

  // capture beats a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_o <= 1'b0;
    else if (hit_o)   flag_o <= 1'b1;
    else if (clr_i)   flag_o <= 1'b0;
  end
endmodule

// File: rtl/ts_regs.sv
module ts_regs
  import ts_cap_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  input  logic [NUM_CH-1:0]              flag_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   cap_i,
  output logic [NUM_CH-1:0][1:0]         edge_cfg_o,
  output logic [NUM_CH-1:0]              ien_o,
  output logic [NUM_CH-1:0]              clr_o
);
  localparam int unsigned CFG_W = 2 * NUM_CH;

  logic wr_edge, wr_ien, wr_flag;

  assign wr_edge = we_i && (addr_i == ADDR_W'(REG_EDGE));
  assign wr_ien  = we_i && (addr_i == ADDR_W'(REG_IEN));
  assign wr_flag = we_i && (addr_i == ADDR_W'(REG_FLAG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_cfg_o <= '0;
      ien_o      <= '0;
    end else begin
      if (wr_edge) edge_cfg_o <= wdata_i[CFG_W-1:0];
      if (wr_ien)  ien_o      <= wdata_i[NUM_CH-1:0];
    end
  end

  assign clr_o = wr_flag ? wdata_i[NUM_CH-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(REG_EDGE)) rdata_o[CFG_W-1:0]  = edge_cfg_o;
    if (addr_i == ADDR_W'(REG_IEN))  rdata_o[NUM_CH-1:0] = ien_o;
    if (addr_i == ADDR_W'(REG_FLAG)) rdata_o[NUM_CH-1:0] = flag_i;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(REG_CAP0 + c)) rdata_o[CNT_W-1:0] = cap_i[c];
    end
  end
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
  import ts_cap_pkg::*;
#(
  parameter int unsigned NUM_CH      = 3,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0][1:0]       edge_cfg;
  logic [NUM_CH-1:0]            ien;
  logic [NUM_CH-1:0]            clr;
  logic [NUM_CH-1:0]            hit;
  logic [NUM_CH-1:0]            flag;
  logic [NUM_CH-1:0][CNT_W-1:0] cap_q;

  ts_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (host_we_i),
    .addr_i    (host_addr_i),
    .wdata_i   (host_wdata_i),
    .rdata_o   (host_rdata_o),
    .flag_i    (flag),
    .cap_i     (cap_q),
    .edge_cfg_o(edge_cfg),
    .ien_o     (ien),
    .clr_o     (clr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ts_cap_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_i[c]),
      .sel_i  (edge_sel_e'(edge_cfg[c])),
      .count_i(count_i),
      .clr_i  (clr[c]),
      .hit_o  (hit[c]),
      .flag_o (flag[c]),
      .cap_o  (cap_q[c])
    );
  end

  assign irq_o = |(flag & ien);
endmodule

// File: rtl/ts_capture_unit_chk.sv
module ts_capture_unit_chk #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CNT_W  = 16
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [CNT_W-1:0]             count_i,
  input logic [NUM_CH-1:0]            hit_i,
  input logic [NUM_CH-1:0]            flag_i,
  input logic [NUM_CH-1:0]            ien_i,
  input logic                         irq_i,
  input logic [NUM_CH-1:0]            clr_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] cap_i,
  input logic [NUM_CH-1:0][1:0]       sel_i
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    AST_CAP_LOADS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[c] |=> cap_i[c] == $past(count_i));                         // R2
    AST_CAP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit_i[c] |=> $stable(cap_i[c]));                                 // R5
    AST_OFF_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_i[c] == 2'b00 |-> !hit_i[c]);                                 // R5
    AST_FLAG_ONLY_BY_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit_i[c] && !flag_i[c] |=> !flag_i[c]);                          // R6
    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_i[c] && clr_i[c] && !hit_i[c] |=> !flag_i[c]);               // R6
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[c] |=> flag_i[c]);                                          // R9
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (|flag_i));                                               // R7
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_i == '0 |-> !irq_i);                                            // R7
endmodule

bind ts_capture_unit ts_capture_unit_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .count_i(count_i),
  .hit_i  (hit),
  .flag_i (flag),
  .ien_i  (ien),
  .irq_i  (irq_o),
  .clr_i  (clr),
  .cap_i  (cap_q),
  .sel_i  (edge_cfg)
);

// File: tb/ts_capture_unit_bench.sv
`timescale 1ns/1ps
module ts_capture_unit_bench;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = 16'h1234;
  logic [2:0]  pin = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [15:0] exp_cap [NCH];

  always #4 clk = ~clk;
  always @(negedge clk) cnt <= cnt + 16'd1;

  ts_capture_unit u_ts_capture_unit (
    .clk_i(clk), .rst_ni(rst_n), .count_i(cnt), .pin_i(pin),
    .host_we_i(we), .host_addr_i(addr), .host_wdata_i(wdata),
    .host_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  // drives pin c to v; returns the count captured if the edge qualifies
  task automatic toggle(input int c, input logic v, output logic [15:0] stamp);
    @(negedge clk); #1; pin[c] = v; stamp = cnt + 16'd2;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] d, stamp;
    for (int c = 0; c < NCH; c++) exp_cap[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a[3:0], d);
      check("R1 reg", d, 16'h0);
    end
    check("R1 irq", {15'b0, irq}, 16'h0);

    // R2 R3 R4 R5 R10 sweep: channel x edge code x direction
    for (int c = 0; c < NCH; c++) begin
      for (int m = 0; m < 4; m++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic rise_case, hit_exp;
          logic [15:0] exp_flags;
          rise_case = (dir == 0);
          wr(4'(0), 16'h0);
          pin[c] = ~rise_case;
          settle();
          wr(4'(0), 16'(m << (2 * c)));
          wr(4'(2), 16'h7);
          toggle(c, rise_case, stamp);
          settle();
          hit_exp = rise_case ? m[0] : m[1];
          if (hit_exp) exp_cap[c] = stamp;
          exp_flags = hit_exp ? 16'(1 << c) : 16'h0;
          rd(4'(2), d);
          case (m)
            0: check("R5 flag disabled", d, exp_flags);
            1: check("R2 flag rising", d, exp_flags);
            2: check("R3 flag falling", d, exp_flags);
            default: check("R4 flag either", d, exp_flags);
          endcase
          for (int k = 0; k < NCH; k++) begin
            rd(4'(3 + k), d);
            if (k != c) check("R10 other cap", d, exp_cap[k]);
            else if (m == 0) check("R5 cap held", d, exp_cap[k]);
            else if (m == 1) check("R2 cap rising", d, exp_cap[k]);
            else if (m == 2) check("R3 cap falling", d, exp_cap[k]);
            else check("R4 cap either", d, exp_cap[k]);
          end
        end
      end
    end

    // R6 write-one-to-clear
    wr(4'(0), 16'h0);
    pin = 3'b000;
    settle();
    wr(4'(0), 16'h0001);
    wr(4'(2), 16'h7);
    toggle(0, 1'b1, stamp);
    settle();
    wr(4'(2), 16'h0006);
    rd(4'(2), d);
    check("R6 zero write keeps flag", d, 16'h0001);
    wr(4'(2), 16'h0001);
    rd(4'(2), d);
    check("R6 one write clears flag", d, 16'h0000);

    // R8 overwrite while flag set
    wr(4'(0), 16'h000C);
    pin[1] = 1'b0;
    settle();
    wr(4'(2), 16'h7);
    toggle(1, 1'b1, stamp);
    settle();
    toggle(1, 1'b0, stamp);
    settle();
    rd(4'(4), d);
    check("R8 cap overwritten", d, stamp);
    rd(4'(2), d);
    check("R8 flag still set", d, 16'h0002);

    // R7 interrupt gating
    wr(4'(1), 16'h0002);
    #1;
    check("R7 irq enabled", {15'b0, irq}, 16'h1);
    wr(4'(1), 16'h0005);
    #1;
    check("R7 irq masked", {15'b0, irq}, 16'h0);
    wr(4'(1), 16'h0002);
    wr(4'(2), 16'h0002);
    #1;
    check("R7 irq after clear", {15'b0, irq}, 16'h0);
    wr(4'(1), 16'h0);

    // R9 capture and clear in the same cycle
    wr(4'(0), 16'h0010);
    pin[2] = 1'b0;
    settle();
    wr(4'(2), 16'h7);
    toggle(2, 1'b1, stamp);
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 4'(2); wdata = 16'h0007;
    @(negedge clk); we = 1'b0;
    rd(4'(2), d);
    check("R9 set wins", d, 16'h0004);
    rd(4'(5), d);
    check("R9 cap value", d, stamp);

    finish_run();
  end
endmodule